// File: doc/BRIEF.md
# Template-Steered Bundle Issue Unit

This block sits between instruction fetch and the execution units of a statically scheduled processor. It receives fixed-size 128-bit bundles on a valid/ready stream. Each bundle holds three 41-bit operations and a 5-bit template. The template says which unit class each of the three operations needs and where the compiler placed a group boundary. The block itself does no dependence analysis. It decodes the template, keeps a window of up to two bundles, and in every cycle sends the longest legal run of pending operations to per-class issue ports.

The run starts at the oldest pending operation and continues in program order across the bundle boundary into the younger bundle. It stops after an operation that carries a stop marker, or just before an operation whose unit class has no free port left in that cycle. Operations that are not sent in a cycle stay in the window and are sent in later cycles. A bundle whose template is reserved is still taken from the stream, but it is discarded and a one-cycle flag is raised. The issue ports are driven from registered window state, so the operations of a newly accepted bundle can appear in the cycle after it is accepted.

Top module: `vliwBundleDispatch`

## Requirements
- R1: The template sits in bundle bits [4:0]. Slot k (k = 0, 1, 2) sits in bits [5+41k +: 41]. An issued operation shows its slot number k on its slot-index field.
- R2: Template bits [4:2] select the slot classes, listed as slot0, slot1, slot2: 0 = M,I,I; 1 = M,M,I; 2 = M,F,I; 3 = M,M,F; 4 = M,I,B; 5 = M,F,B. The class codes are M = 0, I = 1, F = 2, B = 3. Each operation leaves on a port of its own class.
- R3: Template bits [1:0] give the stop: 0 = none, 1 = after slot 2, 2 = after slot 0, 3 = after slot 1. No operation that follows a stop is issued in the same cycle as the operation before the stop.
- R4: A group may cover the rest of the older bundle and the whole of the younger bundle in one cycle, as long as no stop and no port shortage ends it.
- R5: Each class has NPORT ports, numbered by global index class*NPORT+p. Operations of one class fill ports from index p = 0 upward in slot order. When an operation finds its class ports used up, the group ends just before it.
- R6: Templates with bits [4:3] = 2'b11 are reserved. Such a bundle is accepted, none of its operations issues, and badBundle is high for exactly the one cycle after it is accepted.
- R7: bundleReady is low exactly when the window holds two bundles. A bundle held back by this is not lost. Once it is accepted, its operations issue in the following cycle if the window was otherwise empty.
- R8: After reset, bundleReady is high, badBundle is low and no port is valid.
- R9: A port that is not valid drives zero on its operation and slot-index fields.
- R10: Operations issue strictly in program order. No operation issues while an earlier operation in the window is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bundleValid | input | 1 | A bundle is offered |
| bundleReady | output | 1 | The block takes the offered bundle at this edge |
| bundleData | input | 128 | Template and three operation slots |
| issueValid | output | 4*NPORT | One valid per issue port, index class*NPORT+p |
| issueOp | output | 4*NPORT*41 | Operation payload per port |
| issueSlot | output | 4*NPORT*2 | Slot number inside its bundle per port |
| badBundle | output | 1 | One-cycle pulse after a reserved template is accepted |

## Verification
A lone bundle that ends in a stop checks field positions and class steering against the template table. A stop after slot 0 and a stop after slot 1 each show that the group is cut at that point and resumes in the next cycle. A bundle that stalls with the next bundle behind it shows a group crossing the bundle boundary, and a third bundle offered while the window is full shows backpressure without any loss. A run with three memory operations in a row goes past the two memory ports, which separates in-order truncation from slot skipping. Reserved templates, including one followed at once by a legal bundle, show that such bundles are discarded, that the pulse lasts one cycle, and that the stream goes on normally afterwards.

// File: rtl/vliwDispatchPkg.sv
package vliwDispatchPkg;
  parameter int OP_W     = 41;
  parameter int TMPL_W   = 5;
  parameter int SLOT_N   = 3;
  parameter int BUNDLE_W = TMPL_W + SLOT_N * OP_W;
  parameter int CLASS_N  = 4;
  parameter int WIN_N    = 2 * SLOT_N;
  parameter int SRC_W    = $clog2(WIN_N);
  parameter int SIDX_W   = $clog2(SLOT_N);

  typedef enum logic [1:0] {
    UNIT_MEM = 2'd0,
    UNIT_INT = 2'd1,
    UNIT_FP  = 2'd2,
    UNIT_BR  = 2'd3
  } unitKind_e;

  typedef struct packed {
    logic                   legal;
    logic [SLOT_N-1:0][1:0] kind;
    logic [SLOT_N-1:0]      stopAfter;
  } tmplInfo_t;

  // Strobes from the issue control to the slot store
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic moveBtoA;
  } winStrobe_t;

  function automatic tmplInfo_t decodeTmpl(input logic [TMPL_W-1:0] t);
    tmplInfo_t info;
    info.legal     = 1'b1;
    info.kind[0]   = UNIT_MEM;
    info.kind[1]   = UNIT_INT;
    info.kind[2]   = UNIT_INT;
    info.stopAfter = '0;
    case (t[4:2])
      3'd0: begin info.kind[1] = UNIT_INT; info.kind[2] = UNIT_INT; end
      3'd1: begin info.kind[1] = UNIT_MEM; info.kind[2] = UNIT_INT; end
      3'd2: begin info.kind[1] = UNIT_FP;  info.kind[2] = UNIT_INT; end
      3'd3: begin info.kind[1] = UNIT_MEM; info.kind[2] = UNIT_FP;  end
      3'd4: begin info.kind[1] = UNIT_INT; info.kind[2] = UNIT_BR;  end
      3'd5: begin info.kind[1] = UNIT_FP;  info.kind[2] = UNIT_BR;  end
      default: info.legal = 1'b0;
    endcase
    case (t[1:0])
      2'd1:    info.stopAfter = 3'b100;
      2'd2:    info.stopAfter = 3'b001;
      2'd3:    info.stopAfter = 3'b010;
      default: info.stopAfter = 3'b000;
    endcase
    return info;
  endfunction
endpackage

// File: rtl/vliwIssueCtrl.sv
module vliwIssueCtrl import vliwDispatchPkg::*; #(
  parameter int NPORT = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             bundleValid,
  input  logic                             inLegal,
  input  logic [WIN_N-1:0][1:0]            winKind,
  input  logic [WIN_N-1:0]                 winStop,
  output logic                             bundleReady,
  output winStrobe_t                       strobe,
  output logic [CLASS_N*NPORT-1:0]         portValid,
  output logic [CLASS_N*NPORT-1:0][SRC_W-1:0] portSrc,
  output logic                             badBundle
);
  localparam int PORT_N = CLASS_N * NPORT;

  logic              aValid, bValid;
  logic [SLOT_N-1:0] aPend, bPend;
  logic [WIN_N-1:0]  candMask, takeMask;
  logic [SLOT_N-1:0] aPendNext, bPendNext;
  logic              nAValid, nBValid;
  logic [SLOT_N-1:0] nAPend, nBPend;
  logic              accept;

  assign candMask = {bPend & {SLOT_N{bValid}}, aPend & {SLOT_N{aValid}}};

  // Group formation: in-order walk over the window
  always_comb begin
    int   useCnt [CLASS_N];
    int   kindIdx;
    logic blocked;
    blocked   = 1'b0;
    takeMask  = '0;
    portValid = '0;
    portSrc   = '0;
    for (int c = 0; c < CLASS_N; c++) useCnt[c] = 0;
    for (int j = 0; j < WIN_N; j++) begin
      kindIdx = int'(winKind[j]);
      if (candMask[j] && !blocked) begin
        if (useCnt[kindIdx] < NPORT) begin
          takeMask[j] = 1'b1;
          portValid[kindIdx*NPORT + useCnt[kindIdx]] = 1'b1;
          portSrc[kindIdx*NPORT + useCnt[kindIdx]]   = SRC_W'(j);
          useCnt[kindIdx] = useCnt[kindIdx] + 1;
          if (winStop[j]) blocked = 1'b1;
        end else begin
          blocked = 1'b1;
        end
      end
    end
  end

  assign aPendNext   = aPend & ~takeMask[SLOT_N-1:0];
  assign bPendNext   = bPend & ~takeMask[WIN_N-1:SLOT_N];
  assign bundleReady = !bValid;
  assign accept      = bundleValid && bundleReady;

  // Window sequencing
  always_comb begin
    nAValid = 1'b0;
    nBValid = 1'b0;
    nAPend  = '0;
    nBPend  = '0;
    strobe  = '0;
    if (aValid && (aPendNext != '0)) begin
      nAValid = 1'b1;
      nAPend  = aPendNext;
      nBValid = bValid;
      nBPend  = bPendNext;
    end else if (bValid && (bPendNext != '0)) begin
      nAValid         = 1'b1;
      nAPend          = bPendNext;
      strobe.moveBtoA = 1'b1;
    end
    if (accept && inLegal) begin
      if (!nAValid) begin
        nAValid      = 1'b1;
        nAPend       = '1;
        strobe.loadA = 1'b1;
      end else begin
        nBValid      = 1'b1;
        nBPend       = '1;
        strobe.loadB = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid    <= 1'b0;
      bValid    <= 1'b0;
      aPend     <= '0;
      bPend     <= '0;
      badBundle <= 1'b0;
    end else begin
      aValid    <= nAValid;
      bValid    <= nBValid;
      aPend     <= nAPend;
      bPend     <= nBPend;
      badBundle <= accept && !inLegal;
    end
  end

  initial begin
    if (PORT_N < CLASS_N) $error("vliwIssueCtrl: NPORT must be at least 1");
  end
endmodule

// File: rtl/vliwSlotStore.sv
module vliwSlotStore import vliwDispatchPkg::*; #(
  parameter int NPORT = 2
) (
  input  logic                                clk,
  input  logic [BUNDLE_W-1:0]                 bundleData,
  input  winStrobe_t                          strobe,
  input  logic [CLASS_N*NPORT-1:0]            portValid,
  input  logic [CLASS_N*NPORT-1:0][SRC_W-1:0] portSrc,
  output logic                                inLegal,
  output logic [WIN_N-1:0][1:0]               winKind,
  output logic [WIN_N-1:0]                    winStop,
  output logic [CLASS_N*NPORT-1:0]            issueValid,
  output logic [CLASS_N*NPORT*OP_W-1:0]       issueOp,
  output logic [CLASS_N*NPORT*SIDX_W-1:0]     issueSlot
);
  localparam int PORT_N = CLASS_N * NPORT;

  tmplInfo_t      inInfo;
  logic [OP_W-1:0] slotOp [WIN_N];

  assign inInfo  = decodeTmpl(bundleData[TMPL_W-1:0]);
  assign inLegal = inInfo.legal;

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOT_N; s++) begin
      if (strobe.loadA) begin
        slotOp[s]  <= bundleData[TMPL_W + s*OP_W +: OP_W];
        winKind[s] <= inInfo.kind[s];
        winStop[s] <= inInfo.stopAfter[s];
      end else if (strobe.moveBtoA) begin
        slotOp[s]  <= slotOp[s + SLOT_N];
        winKind[s] <= winKind[s + SLOT_N];
        winStop[s] <= winStop[s + SLOT_N];
      end
      if (strobe.loadB) begin
        slotOp[s + SLOT_N]  <= bundleData[TMPL_W + s*OP_W +: OP_W];
        winKind[s + SLOT_N] <= inInfo.kind[s];
        winStop[s + SLOT_N] <= inInfo.stopAfter[s];
      end
    end
  end

  generate
    for (genvar q = 0; q < PORT_N; q++) begin : gPort
      logic [SRC_W-1:0] inBundleIdx;
      assign inBundleIdx = (portSrc[q] >= SRC_W'(SLOT_N)) ? portSrc[q] - SRC_W'(SLOT_N)
                                                         : portSrc[q];
      assign issueValid[q] = portValid[q];
      assign issueOp[q*OP_W +: OP_W] = portValid[q] ? slotOp[portSrc[q]] : '0;
      assign issueSlot[q*SIDX_W +: SIDX_W] = portValid[q] ? SIDX_W'(inBundleIdx) : '0;
    end
  endgenerate
endmodule

// File: rtl/vliwBundleDispatch.sv
module vliwBundleDispatch import vliwDispatchPkg::*; #(
  parameter int NPORT = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            bundleValid,
  output logic                            bundleReady,
  input  logic [BUNDLE_W-1:0]             bundleData,
  output logic [CLASS_N*NPORT-1:0]        issueValid,
  output logic [CLASS_N*NPORT*OP_W-1:0]   issueOp,
  output logic [CLASS_N*NPORT*SIDX_W-1:0] issueSlot,
  output logic                            badBundle
);
  winStrobe_t                          strobe;
  logic                                inLegal;
  logic [WIN_N-1:0][1:0]               winKind;
  logic [WIN_N-1:0]                    winStop;
  logic [CLASS_N*NPORT-1:0]            portValid;
  logic [CLASS_N*NPORT-1:0][SRC_W-1:0] portSrc;

  vliwIssueCtrl #(.NPORT(NPORT)) uCtrl (
    .clk(clk), .rstN(rstN), .bundleValid(bundleValid), .inLegal(inLegal),
    .winKind(winKind), .winStop(winStop), .bundleReady(bundleReady),
    .strobe(strobe), .portValid(portValid), .portSrc(portSrc),
    .badBundle(badBundle)
  );

  vliwSlotStore #(.NPORT(NPORT)) uStore (
    .clk(clk), .bundleData(bundleData), .strobe(strobe),
    .portValid(portValid), .portSrc(portSrc), .inLegal(inLegal),
    .winKind(winKind), .winStop(winStop), .issueValid(issueValid),
    .issueOp(issueOp), .issueSlot(issueSlot)
  );
endmodule

// File: rtl/vliwDispatchChecks.sv
module vliwDispatchChecks import vliwDispatchPkg::*; #(
  parameter int NPORT = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            bundleValid,
  input logic                            bundleReady,
  input logic [1:0]                      tmplTop,
  input logic [CLASS_N*NPORT-1:0]        issueValid,
  input logic [CLASS_N*NPORT*SIDX_W-1:0] issueSlot,
  input logic                            badBundle
);
  // R6: an accepted reserved template raises the flag next cycle
  a_r6_flag_raised: assert property (@(posedge clk) disable iff (!rstN)
    (bundleValid && bundleReady && tmplTop == 2'b11) |=> badBundle);

  // R6: the flag only follows an accepted bundle
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    badBundle |-> $past(bundleValid && bundleReady));

  // R7: a full window always makes progress
  a_r7_full_progress: assert property (@(posedge clk) disable iff (!rstN)
    !bundleReady |-> (|issueValid));

  generate
    for (genvar q = 0; q < CLASS_N*NPORT; q++) begin : gSlot
      // R1: slot index stays inside the bundle
      a_r1_slot_range: assert property (@(posedge clk) disable iff (!rstN)
        issueValid[q] |-> (issueSlot[q*SIDX_W +: SIDX_W] < SIDX_W'(SLOT_N)));
    end
    for (genvar c = 0; c < CLASS_N; c++) begin : gCls
      for (genvar p = 0; p + 1 < NPORT; p++) begin : gOrd
        // R5: ports of one class fill from the lowest index
        a_r5_port_fill: assert property (@(posedge clk) disable iff (!rstN)
          issueValid[c*NPORT + p + 1] |-> issueValid[c*NPORT + p]);
      end
    end
  endgenerate
endmodule

bind vliwBundleDispatch vliwDispatchChecks #(.NPORT(NPORT)) uChecks (
  .clk(clk), .rstN(rstN), .bundleValid(bundleValid), .bundleReady(bundleReady),
  .tmplTop(bundleData[4:3]), .issueValid(issueValid), .issueSlot(issueSlot),
  .badBundle(badBundle)
);

// File: tb/sim_vliwBundleDispatch.sv
`timescale 1ns/1ps
module sim_vliwBundleDispatch;
  localparam int NP = 2;
  localparam int PN = 4 * NP;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           bundleValid = 1'b0;
  logic           bundleReady;
  logic [127:0]   bundleData = '0;
  logic [PN-1:0]  issueValid;
  logic [PN*41-1:0] issueOp;
  logic [PN*2-1:0]  issueSlot;
  logic           badBundle;

  int vecCount = 0;
  int missCount = 0;
  logic        expV    [PN];
  logic [40:0] expOp   [PN];
  logic [1:0]  expSlot [PN];

  always #4 clk = ~clk;

  vliwBundleDispatch #(.NPORT(NP)) u0 (
    .clk(clk), .rstN(rstN), .bundleValid(bundleValid), .bundleReady(bundleReady),
    .bundleData(bundleData), .issueValid(issueValid), .issueOp(issueOp),
    .issueSlot(issueSlot), .badBundle(badBundle)
  );

  function automatic logic [127:0] mk(input logic [4:0] t, input logic [40:0] o0,
                                      input logic [40:0] o1, input logic [40:0] o2);
    return {o2, o1, o0, t};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expClear;
    for (int q = 0; q < PN; q++) begin
      expV[q] = 1'b0; expOp[q] = '0; expSlot[q] = '0;
    end
  endtask

  task automatic expSet(input int cls, input int p, input logic [40:0] op, input int s);
    expV[cls*NP + p]    = 1'b1;
    expOp[cls*NP + p]   = op;
    expSlot[cls*NP + p] = 2'(s);
  endtask

  task automatic checkPorts(input string req);
    for (int q = 0; q < PN; q++) begin
      chk(issueValid[q] == expV[q], req, $sformatf("valid port %0d", q),
          64'(issueValid[q]), 64'(expV[q]));
      chk(issueOp[q*41 +: 41] == expOp[q], req, $sformatf("op port %0d", q),
          64'(issueOp[q*41 +: 41]), 64'(expOp[q]));
      chk(issueSlot[q*2 +: 2] == expSlot[q], req, $sformatf("slot port %0d", q),
          64'(issueSlot[q*2 +: 2]), 64'(expSlot[q]));
    end
  endtask

  task automatic offer(input logic [127:0] b);
    bundleValid = 1'b1;
    bundleData  = b;
  endtask

  task automatic idle;
    bundleValid = 1'b0;
    bundleData  = '0;
  endtask

  // R8 R9: state out of reset
  task automatic testReset;
    chk(bundleReady == 1'b1, "R8", "ready", 64'(bundleReady), 64'd1);
    chk(badBundle == 1'b0, "R8", "badBundle", 64'(badBundle), 64'd0);
    expClear();
    checkPorts("R8");
  endtask

  // R1 R2: one bundle, classes M,F,I, stop at end
  task automatic testSingle;
    logic [40:0] o0 = 41'h101_0000_00A0, o1 = 41'h0A2_0000_00A1, o2 = 41'h1F3_0000_00A2;
    offer(mk(5'b010_01, o0, o1, o2));
    tick();
    idle();
    expClear();
    expSet(0, 0, o0, 0);
    expSet(2, 0, o1, 1);
    expSet(1, 0, o2, 2);
    checkPorts("R1 R2");
    tick();
    expClear();
    checkPorts("R9");
  endtask

  // R3: stop after slot 0, classes M,I,I
  task automatic testStopSlot0;
    logic [40:0] o0 = 41'h0B0_1111_0000, o1 = 41'h0B1_2222_0000, o2 = 41'h0B2_3333_0000;
    offer(mk(5'b000_10, o0, o1, o2));
    tick();
    idle();
    expClear();
    expSet(0, 0, o0, 0);
    checkPorts("R3");
    tick();
    expClear();
    expSet(1, 0, o1, 1);
    expSet(1, 1, o2, 2);
    checkPorts("R3");
    tick();
    expClear();
    checkPorts("R9");
  endtask

  // R3: stop after slot 1, classes M,M,I
  task automatic testStopSlot1;
    logic [40:0] o0 = 41'h0C0_0000_1234, o1 = 41'h0C1_0000_5678, o2 = 41'h0C2_0000_9ABC;
    offer(mk(5'b001_11, o0, o1, o2));
    tick();
    idle();
    expClear();
    expSet(0, 0, o0, 0);
    expSet(0, 1, o1, 1);
    checkPorts("R3");
    tick();
    expClear();
    expSet(1, 0, o2, 2);
    checkPorts("R3");
    tick();
  endtask

  // R4 R7: group across two bundles, full window holds a third bundle back
  task automatic testPairAndHold;
    logic [40:0] a0 = 41'h0D0_0000_0001, a1 = 41'h0D1_0000_0002, a2 = 41'h0D2_0000_0003;
    logic [40:0] b0 = 41'h0E0_0000_0004, b1 = 41'h0E1_0000_0005, b2 = 41'h0E2_0000_0006;
    logic [40:0] c0 = 41'h0F0_0000_0007, c1 = 41'h0F1_0000_0008, c2 = 41'h0F2_0000_0009;
    offer(mk(5'b000_10, a0, a1, a2));
    tick();
    chk(bundleReady == 1'b1, "R7", "ready with one bundle", 64'(bundleReady), 64'd1);
    offer(mk(5'b101_00, b0, b1, b2));
    expClear();
    expSet(0, 0, a0, 0);
    checkPorts("R4");
    tick();
    offer(mk(5'b100_00, c0, c1, c2));
    chk(bundleReady == 1'b0, "R7", "ready with two bundles", 64'(bundleReady), 64'd0);
    expClear();
    expSet(1, 0, a1, 1);
    expSet(1, 1, a2, 2);
    expSet(0, 0, b0, 0);
    expSet(2, 0, b1, 1);
    expSet(3, 0, b2, 2);
    checkPorts("R4");
    tick();
    chk(bundleReady == 1'b1, "R7", "ready after drain", 64'(bundleReady), 64'd1);
    expClear();
    checkPorts("R7");
    tick();
    idle();
    expClear();
    expSet(0, 0, c0, 0);
    expSet(1, 0, c1, 1);
    expSet(3, 0, c2, 2);
    checkPorts("R7");
    tick();
  endtask

  // R5 R10: memory ports run out mid-group, rest waits in order
  task automatic testPortLimit;
    logic [40:0] a0 = 41'h110_0000_00F0, a1 = 41'h111_0000_00F1, a2 = 41'h112_0000_00F2;
    logic [40:0] b0 = 41'h120_0000_00E0, b1 = 41'h121_0000_00E1, b2 = 41'h122_0000_00E2;
    offer(mk(5'b011_10, a0, a1, a2));
    tick();
    offer(mk(5'b001_00, b0, b1, b2));
    expClear();
    expSet(0, 0, a0, 0);
    checkPorts("R5");
    tick();
    idle();
    expClear();
    expSet(0, 0, a1, 1);
    expSet(2, 0, a2, 2);
    expSet(0, 1, b0, 0);
    checkPorts("R5");
    tick();
    expClear();
    expSet(0, 0, b1, 1);
    expSet(1, 0, b2, 2);
    checkPorts("R10");
    tick();
    expClear();
    checkPorts("R10");
  endtask

  // R6: reserved templates are dropped with a one-cycle flag
  task automatic testIllegal;
    logic [40:0] l0 = 41'h130_0000_0C00, l1 = 41'h131_0000_0C01, l2 = 41'h132_0000_0C02;
    offer(mk(5'b110_00, 41'h1, 41'h2, 41'h3));
    tick();
    idle();
    chk(badBundle == 1'b1, "R6", "flag after code 6", 64'(badBundle), 64'd1);
    expClear();
    checkPorts("R6");
    tick();
    chk(badBundle == 1'b0, "R6", "flag one cycle", 64'(badBundle), 64'd0);
    checkPorts("R6");
    offer(mk(5'b111_11, 41'h4, 41'h5, 41'h6));
    tick();
    offer(mk(5'b000_00, l0, l1, l2));
    chk(badBundle == 1'b1, "R6", "flag after code 7", 64'(badBundle), 64'd1);
    expClear();
    checkPorts("R6");
    tick();
    idle();
    chk(badBundle == 1'b0, "R6", "flag clear on legal", 64'(badBundle), 64'd0);
    expClear();
    expSet(0, 0, l0, 0);
    expSet(1, 0, l1, 1);
    expSet(1, 1, l2, 2);
    checkPorts("R6");
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testStopSlot0();
    testStopSlot1();
    testPairAndHold();
    testPortLimit();
    testIllegal();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecCount++;
    missCount++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule